// File: doc/BRIEF.md
# Card Readout Frame Sequencer

This block is the master sequencer for one card's high-speed readout. A start strobe, sampled on a tick, begins a frame. The sequencer sends its header words onto a shared output bus, one word per tick. It then passes a readout token to the first node of a daisy chain of data nodes, which put their own words on the bus. When the token comes back from the last node, the sequencer sends its local data words and its trailer words, and it withdraws the token in the tick of the final trailer word.

Word contents come from a local store that the sequencer reads through a word-select address. Each word is selected one tick before it is driven. The selected word is latched at that tick boundary and placed on the bus in the following tick, with a valid flag. All sequencing moves only on clock edges where the tick enable is high. The clock may run many cycles between ticks.

Top module: `rdo_frame_seq`

## Requirements
- R1: After reset, and whenever no frame is active, `bus_valid`, `tok_out` and `busy` are 0.
- R2: A `start` that is high on a tick while idle makes the next tick a fetch-only tick: `word_sel` = 0 (header word 0), `bus_valid` = 0, and `busy` = 1.
- R3: Store addresses are headers 0..N_HDR-1, then local words from N_HDR, then trailer words after the local words. Every driven word equals the `word_in` value present at its address one tick earlier, and `word_sel` shows the next address during each send tick that has a successor in the same run.
- R4: A frame drives, in fixed order, the header words, then (after the chain) the local words, then the trailer words, with `bus_valid` = 1 in each tick that carries one of them.
- R5: `tok_out` rises in the tick that carries the last header word.
- R6: The tick that follows the last header word carries no word from this block (`bus_valid` = 0), whatever the level of `tok_ret`.
- R7: The block holds `tok_out` high with `bus_valid` low until it samples `tok_ret` high on a tick after the gap tick. The next tick selects local word 0 (`word_sel` = N_HDR) without driving it, and the tick after that sends it.
- R8: In the tick that carries the last trailer word, `tok_out` and `busy` are 0 while `bus_valid` is 1.
- R9: A `start` sampled while `busy` is 1 is ignored, and the frame in progress is unaffected.
- R10: With the default option, `bus_out` is all zeros in every tick where `bus_valid` is 0.
- R11: Outputs change only on clock edges where `tick` is 1. `start` pulses between ticks have no effect.
- R12: A `start` sampled in the tick of the last trailer word begins a new frame immediately, so the next tick is the fetch of header word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Tick enable; sequencing advances only on edges where it is high |
| start | input | 1 | Start strobe, sampled on a tick |
| tok_ret | input | 1 | Token returned from the last chain node |
| word_in | input | DATA_W | Store word at address `word_sel` |
| word_sel | output | SEL_W | Store address fetched in the current tick |
| bus_out | output | DATA_W | Shared output bus data |
| bus_valid | output | 1 | High in ticks where this block drives the bus |
| tok_out | output | 1 | Readout token to the first chain node |
| busy | output | 1 | High from start acceptance until the token is withdrawn |

## Verification
The hardest situations to reach from the ports are those where `tok_ret` is already high while the headers are still being sent, and where a new start arrives in the same tick as the last trailer word. Both depend on the exact tick in which the inputs are held. The bench sweeps the chain delay from zero to six ticks. For each delay it runs with and without `tok_ret` asserted early, and with and without `start` held high during the whole frame. Alternate frames are chained back to back through the final trailer tick. Between ticks the bench toggles `start`, and it checks every tick of every frame against a position-by-position model.

// File: rtl/rdo_seq_pkg.sv
package rdo_seq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_FHEAD = 3'd1,
      PH_HEAD  = 3'd2,
      PH_GAP   = 3'd3,
      PH_FTAIL = 3'd4,
      PH_TAIL  = 3'd5
   } phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rdo_seq_ctrl.sv
module rdo_seq_ctrl
   import rdo_seq_pkg::*;
#(
   parameter int unsigned N_HDR  = 2,
   parameter int unsigned N_TAIL = 6,
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             tok_ret,
   output logic             fetch,
   output logic [SEL_W-1:0] sel,
   output logic             drive,
   output logic             tok_out,
   output logic             busy
);
   localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(N_HDR - 1);
   localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(N_TAIL - 1);
   localparam logic [SEL_W-1:0] TAIL_BASE = SEL_W'(N_HDR);

   phase_e           phase;
   logic [CNT_W-1:0] idx;
   logic             last_hdr;
   logic             last_tail;

   assign last_hdr  = (phase == PH_HEAD) && (idx == HDR_LAST);
   assign last_tail = (phase == PH_TAIL) && (idx == TAIL_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
      end else if (tick) begin
         unique case (phase)
            PH_IDLE: begin
               if (start) phase <= PH_FHEAD;
            end
            PH_FHEAD: begin
               phase <= PH_HEAD;
               idx   <= '0;
            end
            PH_HEAD: begin
               if (last_hdr) begin
                  phase <= PH_GAP;
                  idx   <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            PH_GAP: begin
               if (tok_ret) phase <= PH_FTAIL;
            end
            PH_FTAIL: begin
               phase <= PH_TAIL;
               idx   <= '0;
            end
            PH_TAIL: begin
               if (last_tail) begin
                  phase <= start ? PH_FHEAD : PH_IDLE;
                  idx   <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      fetch = 1'b0;
      sel   = '0;
      unique case (phase)
         PH_FHEAD: fetch = 1'b1;
         PH_HEAD: if (!last_hdr) begin
            fetch = 1'b1;
            sel   = SEL_W'(idx) + SEL_W'(1);
         end
         PH_FTAIL: begin
            fetch = 1'b1;
            sel   = TAIL_BASE;
         end
         PH_TAIL: if (!last_tail) begin
            fetch = 1'b1;
            sel   = TAIL_BASE + SEL_W'(idx) + SEL_W'(1);
         end
         default: ;
      endcase
   end

   assign drive   = (phase == PH_HEAD) || (phase == PH_TAIL);
   assign tok_out = last_hdr || (phase == PH_GAP) || (phase == PH_FTAIL) ||
                    ((phase == PH_TAIL) && !last_tail);
   assign busy    = (phase != PH_IDLE) && !last_tail;
endmodule

// File: rtl/rdo_word_pipe.sv
module rdo_word_pipe #(
   parameter int unsigned DATA_W    = 16,
   parameter bit          RELEASE_Z = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              fetch,
   input  logic              drive,
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_valid
);
   logic [DATA_W-1:0] hold;

   always_ff @(posedge clk) begin
      if (!rst_n)              hold <= '0;
      else if (tick && fetch)  hold <= word_in;
   end

   assign bus_valid = drive;

   generate
      if (RELEASE_Z) begin : g_release_z
         assign bus_out = drive ? hold : 'z;
      end else begin : g_release_zero
         assign bus_out = drive ? hold : '0;
      end
   endgenerate
endmodule

// File: rtl/rdo_frame_seq.sv
module rdo_frame_seq
   import rdo_seq_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned N_HDR     = 2,
   parameter int unsigned N_LOC     = 4,
   parameter int unsigned N_TRL     = 2,
   parameter bit          RELEASE_Z = 1'b0,
   localparam int unsigned N_TAIL   = N_LOC + N_TRL,
   localparam int unsigned N_WORDS  = N_HDR + N_TAIL,
   localparam int unsigned SEL_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              tok_ret,
   input  logic [DATA_W-1:0] word_in,
   output logic [SEL_W-1:0]  word_sel,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_valid,
   output logic              tok_out,
   output logic              busy
);
   localparam int unsigned CNT_W = $clog2(max2(N_HDR, N_TAIL) + 1);

   generate
      if (N_HDR < 1) begin : g_bad_hdr
         $error("rdo_frame_seq: N_HDR must be at least 1");
      end
      if (N_TRL < 1) begin : g_bad_trl
         $error("rdo_frame_seq: N_TRL must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("rdo_frame_seq: DATA_W must be at least 1");
      end
   endgenerate

   logic fetch;
   logic drive;

   rdo_seq_ctrl #(
      .N_HDR (N_HDR),
      .N_TAIL(N_TAIL),
      .SEL_W (SEL_W),
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .start  (start),
      .tok_ret(tok_ret),
      .fetch  (fetch),
      .sel    (word_sel),
      .drive  (drive),
      .tok_out(tok_out),
      .busy   (busy)
   );

   rdo_word_pipe #(
      .DATA_W   (DATA_W),
      .RELEASE_Z(RELEASE_Z)
   ) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .fetch    (fetch),
      .drive    (drive),
      .word_in  (word_in),
      .bus_out  (bus_out),
      .bus_valid(bus_valid)
   );
endmodule

// File: rtl/rdo_frame_seq_chk.sv
module rdo_frame_seq_chk #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SEL_W     = 3,
   parameter bit          RELEASE_Z = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [SEL_W-1:0]  word_sel,
   input logic [DATA_W-1:0] bus_out,
   input logic              bus_valid,
   input logic              tok_out,
   input logic              busy
);
   // R5: the token comes up together with a driven header word
   a_r5_tok_rise_with_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tok_out) |-> bus_valid && busy);

   // R8: the token is withdrawn in the last trailer tick, busy drops with it
   a_r8_tok_fall_last_word: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tok_out) |-> bus_valid && !busy);

   // R2: a new frame opens with a fetch-only tick of address 0
   a_r2_open_fetch_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !bus_valid && (word_sel == '0) && !tok_out);

   // R10: released bus reads as zero
   a_r10_bus_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!RELEASE_Z && !bus_valid) |-> (bus_out == '0));

   // R11: nothing moves without a tick
   a_r11_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(bus_valid) && $stable(tok_out) && $stable(busy) && $stable(word_sel));

   // R1: idle means no token and no drive
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !tok_out) |-> (!bus_valid || $fell(tok_out) || !$past(busy)));
endmodule

bind rdo_frame_seq rdo_frame_seq_chk #(
   .DATA_W   (DATA_W),
   .SEL_W    (SEL_W),
   .RELEASE_Z(RELEASE_Z)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .word_sel (word_sel),
   .bus_out  (bus_out),
   .bus_valid(bus_valid),
   .tok_out  (tok_out),
   .busy     (busy)
);

// File: tb/tb_rdo_frame_seq.sv
`timescale 1ns/1ps
module tb_rdo_frame_seq;
   localparam int DW  = 16;
   localparam int SW  = 3;
   localparam int NH  = 2;
   localparam int NT  = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          start = 1'b0;
   logic          tok_ret = 1'b0;
   logic [DW-1:0] word_in;
   logic [SW-1:0] word_sel;
   logic [DW-1:0] bus_out;
   logic          bus_valid;
   logic          tok_out;
   logic          busy;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   rdo_frame_seq dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .start    (start),
      .tok_ret  (tok_ret),
      .word_in  (word_in),
      .word_sel (word_sel),
      .bus_out  (bus_out),
      .bus_valid(bus_valid),
      .tok_out  (tok_out),
      .busy     (busy)
   );

   function automatic logic [DW-1:0] wf(input int a);
      return DW'(16'h3C00 + a * 16'h0123) ^ 16'h00A5;
   endfunction

   always_comb word_in = wf(int'(word_sel));

   task automatic cmp(input string rq, input string what, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic expect_out(input string rq, input logic ev, input int ea,
                             input logic et, input logic eb, input int es);
      cmp(rq, "bus_valid", DW'(bus_valid), DW'(ev));
      if (ev) cmp(rq, "bus_out", bus_out, wf(ea));
      else    cmp("R10", "bus_out", bus_out, '0);
      cmp(rq, "tok_out", DW'(tok_out), DW'(et));
      cmp(rq, "busy", DW'(busy), DW'(eb));
      if (es >= 0) cmp(rq, "word_sel", DW'(word_sel), DW'(es));
   endtask

   // one tick; start noise between ticks (R11)
   task automatic step(input logic st, input logic rt);
      @(negedge clk);
      tick = 1'b1; start = st; tok_ret = rt;
      @(negedge clk);
      tick = 1'b0; start = 1'b1; tok_ret = ~rt;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_frame(input int w, input bit early, input bit spam, input string open_rq);
      string tg;
      tg = spam ? "R9/R4" : "R4";
      step(1'b1, early);
      expect_out(open_rq, 1'b0, 0, 1'b0, 1'b1, 0);
      step(spam, early);
      expect_out("R3", 1'b1, 0, 1'b0, 1'b1, 1);
      step(spam, early);
      expect_out("R5", 1'b1, 1, 1'b1, 1'b1, -1);
      step(spam, early);
      expect_out("R6", 1'b0, 0, 1'b1, 1'b1, -1);
      for (int i = 0; i < w; i++) begin
         step(spam, 1'b0);
         expect_out("R7", 1'b0, 0, 1'b1, 1'b1, -1);
      end
      step(spam, 1'b1);
      expect_out("R7", 1'b0, 0, 1'b1, 1'b1, NH);
      for (int j = 0; j < NT; j++) begin
         step(spam, 1'b0);
         if (j < NT - 1) expect_out(tg, 1'b1, NH + j, 1'b1, 1'b1, NH + j + 1);
         else            expect_out("R8", 1'b1, NH + j, 1'b0, 1'b0, -1);
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit chained;
      repeat (3) @(negedge clk);
      expect_out("R1", 1'b0, 0, 1'b0, 1'b0, -1);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R1", 1'b0, 0, 1'b0, 1'b0, -1);
      step(1'b0, 1'b0);
      expect_out("R11", 1'b0, 0, 1'b0, 1'b0, -1);
      chained = 1'b0;
      for (int w = 0; w <= 6; w++) begin
         for (int e = 0; e < 2; e++) begin
            for (int s = 0; s < 2; s++) begin
               run_frame(w, e[0], s[0], chained ? "R12" : "R2");
               chained = ((w + e + s) % 2) == 1;
               if (!chained) begin
                  step(1'b0, 1'b1);
                  expect_out("R1", 1'b0, 0, 1'b0, 1'b0, -1);
               end
            end
         end
      end
      if (chained) begin
         step(1'b0, 1'b0);
         expect_out("R1", 1'b0, 0, 1'b0, 1'b0, -1);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule